// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter

This block is a presettable binary counter built from identical 8-bit stages. Every stage's count register changes only on the rising edge of a single clock. A 2-bit operation select picks one of four operations: synchronous clear, count down, parallel load and count up. Two active-low enables gate counting. One of them, the carry-gating enable, is also needed before a stage can report reaching its terminal value on its active-low carry output.

The top module chains `STAGES` stages. The first stage takes its carry-gating enable from the port `cnt_ena_t_n`. Each later stage takes it from the carry output of the stage below. The last stage's carry appears on `carry_n`. This carry chain is the only link between stages, and with it the chain counts as one wide synchronous counter. Clear and load act on all stages together.

The "state machine" of the block is the count value, and the operation select names its transitions:
- CLEAR (00) goes to zero.
- DOWN (01) goes to value−1 when enabled, otherwise it holds.
- LOAD (10) goes to the data word.
- UP (11) goes to value+1 when enabled, otherwise it holds.

Top module: `updn_chain`

## Requirements
- R1: While `rst_n` is low the count is 0. Otherwise the count register changes only on a rising edge of `clk`, with all bits updating together.
- R2: With `op_sel` = 2'b10 (load), the count equals `load_data` after the next rising edge, whatever the enables are.
- R3: With `op_sel` = 2'b00 (clear), the count is 0 after the next rising edge, whatever the enables are. It does not change before that edge.
- R4: With `op_sel` = 2'b11 or 2'b01 and either `cnt_ena_p_n` or `cnt_ena_t_n` high, the count holds across the edge.
- R5: With `op_sel` = 2'b11 and both enables low, the count goes up by one at each edge. All ones wraps to 0.
- R6: With `op_sel` = 2'b01 and both enables low, the count goes down by one at each edge. 0 wraps to all ones.
- R7: `carry_n` is low exactly when `cnt_ena_t_n` is low and the full count is at its terminal value. That value is all ones for `op_sel` = 2'b11 and zero for `op_sel` = 2'b01. In clear and load modes `carry_n` is high.
- R8: Whenever `cnt_ena_t_n` is high, `carry_n` is high.
- R9: A stage above the lowest counts only when every stage below it is at its terminal value. The chain therefore steps correctly across the 8-bit boundary (0x00FF to 0x0100 up, and the reverse down).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low start-up reset, count to 0 |
| load_data | input | STAGES*STAGE_W | Parallel preset word |
| op_sel | input | 2 | Operation: 00 clear, 01 down, 10 load, 11 up |
| cnt_ena_p_n | input | 1 | Active-low count enable, shared by all stages |
| cnt_ena_t_n | input | 1 | Active-low count and carry-gating enable of the lowest stage |
| count | output | STAGES*STAGE_W | Current count |
| carry_n | output | 1 | Active-low terminal-count carry of the top stage |

## Verification
The hardest case to reach from the ports is the cascade boundary. The upper byte changes only after the lower byte has run through all 256 values in one direction with the enables held low. Random counting alone rarely gets there. The stimulus therefore loads values just below and just above 0x0100, 0xFFFF and 0x0000, then runs directed bursts and random counting around them. The carry is compared with the bench model on every cycle, both before and after the inputs change.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'b00,
        OP_DOWN  = 2'b01,
        OP_LOAD  = 2'b10,
        OP_UP    = 2'b11
    } op_e;

endpackage

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    input  op_e          op,
    input  logic         step_ok,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_UP:    nxt = step_ok ? cur + ONE : cur;
            OP_DOWN:  nxt = step_ok ? cur - ONE : cur;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  op_e          op,
    input  logic         gate_n,
    output logic         carry_n
);
    logic at_top;
    logic at_bottom;
    logic term;

    assign at_top    = &cur;
    assign at_bottom = ~|cur;

    always_comb begin
        unique case (op)
            OP_UP:   term = at_top;
            OP_DOWN: term = at_bottom;
            default: term = 1'b0;
        endcase
        carry_n = ~(term & ~gate_n);
    end
endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  op_e          op,
    input  logic         ena_p_n,
    input  logic         ena_t_n,
    output logic [W-1:0] q,
    output logic         carry_n
);
    logic [W-1:0] q_nxt;
    logic         step_ok;

    assign step_ok = ~ena_p_n & ~ena_t_n;

    updn_next #(.W(W)) u_next (
        .cur(q), .din(din), .op(op), .step_ok(step_ok), .nxt(q_nxt)
    );

    updn_term #(.W(W)) u_term (
        .cur(q), .op(op), .gate_n(ena_t_n), .carry_n(carry_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (q == '0));                                   // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (q == $past(din)));                            // R2
    AST_HOLD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == OP_UP || op == OP_DOWN) && (ena_p_n || ena_t_n)) |=> $stable(q)); // R4
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UP && !ena_p_n && !ena_t_n) |=> (q == W'($past(q) + 1'b1)));    // R5
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN && !ena_p_n && !ena_t_n) |=> (q == W'($past(q) - 1'b1)));  // R6
    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ena_t_n |-> carry_n);                                              // R8
    AST_CARRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR || op == OP_LOAD) |-> carry_n);                    // R7
endmodule

// File: rtl/updn_chain.sv
module updn_chain
    import updn_pkg::*;
#(
    parameter int STAGE_W = 8,
    parameter int STAGES  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [STAGES*STAGE_W-1:0]   load_data,
    input  logic [1:0]                  op_sel,
    input  logic                        cnt_ena_p_n,
    input  logic                        cnt_ena_t_n,
    output logic [STAGES*STAGE_W-1:0]   count,
    output logic                        carry_n
);
    localparam int TOTAL_W = STAGES * STAGE_W;

    op_e         op;
    logic [STAGES:0] gate_n;

    assign op        = op_e'(op_sel);
    assign gate_n[0] = cnt_ena_t_n;
    assign carry_n   = gate_n[STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (load_data[s*STAGE_W +: STAGE_W]),
            .op      (op),
            .ena_p_n (cnt_ena_p_n),
            .ena_t_n (gate_n[s]),
            .q       (count[s*STAGE_W +: STAGE_W]),
            .carry_n (gate_n[s+1])
        );
    end

    AST_CHAIN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_UP && !cnt_ena_p_n && !cnt_ena_t_n) |=> (count == TOTAL_W'($past(count) + 1'b1))); // R9
    AST_CHAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN && !cnt_ena_p_n && !cnt_ena_t_n) |=> (count == TOTAL_W'($past(count) - 1'b1))); // R9
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (count == '0));                                         // R1
endmodule

// File: tb/updn_chain_bench.sv
module updn_chain_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] load_data = '0;
    logic [1:0]   op_sel = 2'b10;
    logic         cnt_ena_p_n = 1'b1;
    logic         cnt_ena_t_n = 1'b1;
    logic [W-1:0] count;
    logic         carry_n;

    int n_run = 0;
    int n_fail = 0;
    logic [W-1:0] model = '0;
    logic [W-1:0] prev = '0;
    logic [1:0]   last_op = 2'b00;
    logic         last_en = 1'b0;
    bit           done = 0;

    always #10 clk = ~clk;

    updn_chain u_updn_chain (
        .clk(clk), .rst_n(rst_n), .load_data(load_data), .op_sel(op_sel),
        .cnt_ena_p_n(cnt_ena_p_n), .cnt_ena_t_n(cnt_ena_t_n),
        .count(count), .carry_n(carry_n)
    );

    function automatic logic exp_carry(logic [W-1:0] c, logic [1:0] op, logic tn);
        logic term;
        term = (op == 2'b11 && c == '1) || (op == 2'b01 && c == '0);
        return !(term && !tn);
    endfunction

    function automatic logic [W-1:0] exp_next(logic [W-1:0] c, logic [W-1:0] d,
                                              logic [1:0] op, logic pn, logic tn);
        case (op)
            2'b00:   return '0;
            2'b10:   return d;
            2'b11:   return (!pn && !tn) ? c + 1'b1 : c;
            default: return (!pn && !tn) ? c - 1'b1 : c;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string count_req();
        if (last_op == 2'b00) return "R3";
        if (last_op == 2'b10) return "R2";
        if (!last_en) return "R4";
        if (prev[7:0] == 8'hFF && last_op == 2'b11) return "R9";
        if (prev[7:0] == 8'h00 && last_op == 2'b01) return "R9";
        return (last_op == 2'b11) ? "R5" : "R6";
    endfunction

    // one cycle: at negedge check state, apply inputs, check carry, predict
    task automatic cycle(logic [1:0] op, logic [W-1:0] d, logic pn, logic tn);
        @(negedge clk);
        chk(count_req(), 32'(count), 32'(model));
        chk(cnt_ena_t_n ? "R8" : "R7", 32'(carry_n), 32'(exp_carry(model, op_sel, cnt_ena_t_n)));
        op_sel = op; load_data = d; cnt_ena_p_n = pn; cnt_ena_t_n = tn;
        #1;
        chk(tn ? "R8" : "R7", 32'(carry_n), 32'(exp_carry(model, op, tn)));
        chk("R3", 32'(count), 32'(model)); // no change before the edge
        prev = model; last_op = op; last_en = !pn && !tn;
        model = exp_next(model, d, op, pn, tn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (2) @(negedge clk);
        chk("R1", 32'(count), 32'h0);
        rst_n = 1'b1;
        // directed corners
        cycle(2'b10, 16'hABCD, 1'b1, 1'b1);          // load with enables high
        cycle(2'b00, 16'h0000, 1'b1, 1'b1);          // clear with enables high
        cycle(2'b10, 16'h00FE, 1'b0, 1'b0);
        repeat (4) cycle(2'b11, 16'h0, 1'b0, 1'b0);  // cross 0x00FF upward
        repeat (5) cycle(2'b01, 16'h0, 1'b0, 1'b0);  // back across downward
        cycle(2'b10, 16'hFFFE, 1'b0, 1'b0);
        repeat (3) cycle(2'b11, 16'h0, 1'b0, 1'b0);  // wrap top
        repeat (3) cycle(2'b01, 16'h0, 1'b0, 1'b0);  // wrap bottom
        cycle(2'b11, 16'h0, 1'b1, 1'b0);             // hold, p high
        cycle(2'b01, 16'h0, 1'b0, 1'b1);             // hold, t high
        cycle(2'b10, 16'hFFFF, 1'b0, 1'b0);
        cycle(2'b11, 16'h0, 1'b1, 1'b0);             // carry low at top, p high
        cycle(2'b11, 16'h0, 1'b1, 1'b1);             // carry gated off
        // constrained random
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] op;
            logic [W-1:0] d;
            int r;
            r = $urandom_range(0, 99);
            op = (r < 4) ? 2'b00 : (r < 10) ? 2'b10 : (r < 55) ? 2'b11 : 2'b01;
            case ($urandom_range(0, 5))
                0: d = 16'h00FD;
                1: d = 16'h0102;
                2: d = 16'hFFFD;
                3: d = 16'h0002;
                default: d = 16'($urandom());
            endcase
            cycle(op, d, ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0));
        end
        @(negedge clk);
        chk(count_req(), 32'(count), 32'(model));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule